// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Load Controller

This block is the register logic in front of a bank of converter channels. Each channel has a data register that software writes over a simple register bus. It also has an output latch that holds the code the converter actually sees. A configuration register gives every channel two bits. The first chooses between immediate and deferred (synchronous) update of the latch. The second is a gain-select bit that is passed straight to the output amplifier control.

A channel in deferred mode keeps its latch unchanged until a global load event. At that event every deferred channel copies its data register into its latch in the same clock cycle. A load event comes from one of two sources:
- a rising edge on an asynchronous external load pin, which is synchronized first;
- a write of one key word to a dedicated load register. That register clears itself once it has fired the strobe.

Top module: `dac_load_ctrl`

## Requirements
- R1: After reset, every data register, every latch, the configuration register and the load register are zero. `dac_code` and `gain_sel` are therefore zero.
- R2: In the configuration register (address 8), bit 8+n set puts channel n in deferred mode. Bit n drives `gain_sel[n]`. The register reads back the value last written.
- R3: Write to the data register of a channel in immediate mode (configuration bit 8+n clear). The latch takes the low 12 bits of the written word on the same clock edge as the data register.
- R4: Write to the data register of a channel in deferred mode. Only the data register changes, and the latch keeps its value.
- R5: Write 0xBB00 to the load register (address 9). This raises an internal strobe for one cycle, in the cycle after the write. On the edge that ends that cycle, every deferred channel copies its data register into its latch. Immediate-mode channels are not affected by any load event.
- R6: Any other value written to the load register starts no load. The value stays there and reads back unchanged.
- R7: The load register reads 0xBB00 during the strobe cycle and reads zero from the next cycle on. A new write to it in that cycle takes precedence over the clear.
- R8: A rising edge on `ext_load` passes through a two-flop synchronizer and an edge detector. The resulting load lands on the third rising clock edge after the pin rises. Holding the pin high gives no further loads.
- R9: A data write to a deferred channel can coincide with a load event. In that case the latch takes the old data register value, and the data register takes the new word.
- R10: Addresses 0 to 7 select the data registers of channels 0 to 7. These read back zero-extended to 16 bits. Addresses 10 to 15 ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| ext_load | input | 1 | Asynchronous external load request, acts on its rising edge |
| dac_code | output | 96 | Eight 12-bit latch values, channel n at bits 12n+11:12n |
| gain_sel | output | 8 | Per-channel gain select |

## Verification
The bench targets three corner cases:
- A data write that coincides with the key-word strobe. A design that let the write bypass the data register would latch the new word instead of the old one.
- Near-miss key values such as 0xBB01. A design that decodes too few bits would fire a load on them, and one that drops the value would read back zero.
- The external pin held high over many cycles. A level-sensitive design keeps reloading, so later deferred writes leak through. One with the wrong synchronizer depth updates a cycle early or late.

Random writes that flip channels between modes check that gain bits and immediate-mode latches follow the model exactly.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;

   localparam logic [15:0] LOAD_KEY_DEFAULT = 16'hBB00;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_CFG  = 2'd1,
      SEL_LOAD = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/dac_load_edge.sv
module dac_load_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dac_load_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_async};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_pulse = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dac_load_decode.sv
module dac_load_decode
   import dac_load_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 4
) (
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output reg_sel_e          sel,
   output logic [NUM_CH-1:0] ch_we,
   output logic              cfg_we,
   output logic              ld_we
);
   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NUM_CH);
   localparam logic [ADDR_W-1:0] LD_ADDR  = ADDR_W'(NUM_CH + 1);

   always_comb begin
      if (bus_addr < CFG_ADDR)       sel = SEL_DATA;
      else if (bus_addr == CFG_ADDR) sel = SEL_CFG;
      else if (bus_addr == LD_ADDR)  sel = SEL_LOAD;
      else                           sel = SEL_NONE;
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_we
      assign ch_we[n] = bus_we && (bus_addr == ADDR_W'(n));
   end

   assign cfg_we = bus_we && (sel == SEL_CFG);
   assign ld_we  = bus_we && (sel == SEL_LOAD);
endmodule

// File: rtl/dac_load_chan.sv
module dac_load_chan #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sync_en,
   input  logic              load,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] latch_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         latch_q <= '0;
      end else begin
         if (wr) data_q <= wdata;
         if (sync_en) begin
            if (load) latch_q <= data_q;
         end else if (wr) begin
            latch_q <= wdata;
         end
      end
   end
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
   import dac_load_pkg::*;
#(
   parameter int          NUM_CH      = 8,
   parameter int          DATA_W      = 12,
   parameter int          REG_W       = 16,
   parameter int          ADDR_W      = 4,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] LOAD_KEY    = LOAD_KEY_DEFAULT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [REG_W-1:0]         bus_wdata,
   output logic [REG_W-1:0]         bus_rdata,
   input  logic                     ext_load,
   output logic [NUM_CH*DATA_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        gain_sel
);
   localparam int CFG_W = 2 * NUM_CH;

   if (CFG_W != REG_W) begin : g_bad_cfg
      $error("dac_load_ctrl: two config bits per channel must fill REG_W");
   end
   if (DATA_W > REG_W) begin : g_bad_data
      $error("dac_load_ctrl: DATA_W exceeds REG_W");
   end
   if (NUM_CH + 2 > (1 << ADDR_W)) begin : g_bad_addr
      $error("dac_load_ctrl: address space too small");
   end
   if (REG_W != 16) begin : g_bad_key
      $error("dac_load_ctrl: load key is 16 bits wide");
   end

   reg_sel_e                 sel;
   logic [NUM_CH-1:0]        ch_we;
   logic                     cfg_we;
   logic                     ld_we;
   logic [CFG_W-1:0]         cfg_q;
   logic [REG_W-1:0]         ld_q;
   logic                     key_strobe;
   logic                     ext_pulse;
   logic                     load_fire;
   logic [NUM_CH*DATA_W-1:0] data_flat;
   logic [NUM_CH-1:0]        sync_en;

   dac_load_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_decode (
      .bus_we  (bus_we),
      .bus_addr(bus_addr),
      .sel     (sel),
      .ch_we   (ch_we),
      .cfg_we  (cfg_we),
      .ld_we   (ld_we)
   );

   dac_load_edge #(.STAGES(SYNC_STAGES)) i_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (ext_load),
      .rise_pulse(ext_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         ld_q  <= '0;
      end else begin
         if (cfg_we) cfg_q <= bus_wdata;
         if (ld_we)           ld_q <= bus_wdata;
         else if (key_strobe) ld_q <= '0;
      end
   end

   assign key_strobe = (ld_q == LOAD_KEY);
   assign load_fire  = key_strobe | ext_pulse;
   assign sync_en    = cfg_q[CFG_W-1:NUM_CH];
   assign gain_sel   = cfg_q[NUM_CH-1:0];

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      dac_load_chan #(.DATA_W(DATA_W)) i_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (ch_we[n]),
         .wdata  (bus_wdata[DATA_W-1:0]),
         .sync_en(sync_en[n]),
         .load   (load_fire),
         .data_q (data_flat[n*DATA_W +: DATA_W]),
         .latch_q(dac_code[n*DATA_W +: DATA_W])
      );
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_DATA: begin
            for (int n = 0; n < NUM_CH; n++) begin
               if (bus_addr == ADDR_W'(n)) bus_rdata = REG_W'(data_flat[n*DATA_W +: DATA_W]);
            end
         end
         SEL_CFG:  bus_rdata = cfg_q;
         SEL_LOAD: bus_rdata = ld_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dac_load_chk.sv
module dac_load_chk #(
   parameter int          NUM_CH   = 8,
   parameter int          DATA_W   = 12,
   parameter int          REG_W    = 16,
   parameter int          ADDR_W   = 4,
   parameter logic [15:0] LOAD_KEY = 16'hBB00
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_we,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [REG_W-1:0]         bus_wdata,
   input logic [2*NUM_CH-1:0]      cfg_q,
   input logic [REG_W-1:0]         ld_q,
   input logic                     load_fire,
   input logic                     ext_pulse,
   input logic [NUM_CH*DATA_W-1:0] data_flat,
   input logic [NUM_CH*DATA_W-1:0] dac_code
);
   localparam logic [ADDR_W-1:0] LD_ADDR = ADDR_W'(NUM_CH + 1);

   // R7: the key clears itself unless rewritten
   a_r7_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_q == LOAD_KEY && !(bus_we && bus_addr == LD_ADDR)) |=> (ld_q == '0));

   // R8: the synchronized edge gives a one-cycle pulse
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ext_pulse |=> !ext_pulse);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      a_r3_async_write: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(n) && !cfg_q[NUM_CH+n])
         |=> (dac_code[n*DATA_W +: DATA_W] == $past(bus_wdata[DATA_W-1:0])));

      a_r5_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
         (load_fire && cfg_q[NUM_CH+n])
         |=> (dac_code[n*DATA_W +: DATA_W] == $past(data_flat[n*DATA_W +: DATA_W])));

      a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!(load_fire && cfg_q[NUM_CH+n]) &&
          !(bus_we && bus_addr == ADDR_W'(n) && !cfg_q[NUM_CH+n]))
         |=> $stable(dac_code[n*DATA_W +: DATA_W]));
   end
endmodule

bind dac_load_ctrl dac_load_chk #(
   .NUM_CH  (NUM_CH),
   .DATA_W  (DATA_W),
   .REG_W   (REG_W),
   .ADDR_W  (ADDR_W),
   .LOAD_KEY(LOAD_KEY)
) i_dac_load_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .cfg_q    (cfg_q),
   .ld_q     (ld_q),
   .load_fire(load_fire),
   .ext_pulse(ext_pulse),
   .data_flat(data_flat),
   .dac_code (dac_code)
);

// File: tb/test_dac_load_ctrl.sv
module test_dac_load_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] KEY = 16'hBB00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        ext_load = 1'b0;
   logic [95:0] dac_code;
   logic [7:0]  gain_sel;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [11:0] exp_data [8];
   logic [11:0] exp_latch [8];
   logic [15:0] exp_cfg;
   logic [15:0] exp_ld;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_load_ctrl i_dac_load_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_load(ext_load),
      .dac_code(dac_code), .gain_sel(gain_sel)
   );

   function automatic logic [95:0] pack_lat();
      logic [95:0] r;
      for (int i = 0; i < 8; i++) r[i*12 +: 12] = exp_latch[i];
      return r;
   endfunction

   function automatic void m_write(logic [3:0] a, logic [15:0] d);
      if (a < 8) begin
         exp_data[a[2:0]] = d[11:0];
         if (!exp_cfg[8 + a]) exp_latch[a[2:0]] = d[11:0];
      end else if (a == 8) exp_cfg = d;
      else if (a == 9) exp_ld = d;
   endfunction

   function automatic void m_load();
      for (int i = 0; i < 8; i++) if (exp_cfg[8+i]) exp_latch[i] = exp_data[i];
   endfunction

   function automatic logic [15:0] m_read(logic [3:0] a);
      if (a < 8) return {4'h0, exp_data[a[2:0]]};
      if (a == 8) return exp_cfg;
      if (a == 9) return exp_ld;
      return 16'h0;
   endfunction

   task automatic chk(string req, logic [95:0] act, logic [95:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // called at a negedge; commits on the next posedge; returns at the next negedge
   task automatic wr(logic [3:0] a, logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      m_write(a, d);
   endtask

   task automatic idle();
      bus_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd_chk(string req, logic [3:0] a);
      bus_we = 1'b0; bus_addr = a;
      #1;
      chk(req, 96'(bus_rdata), 96'(m_read(a)));
   endtask

   task automatic out_chk(string req);
      chk({req, " latches"}, dac_code, pack_lat());
      chk({req, " gain"}, 96'(gain_sel), 96'(exp_cfg[7:0]));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 8; i++) begin exp_data[i] = '0; exp_latch[i] = '0; end
      exp_cfg = '0; exp_ld = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      out_chk("R1");
      rd_chk("R1 cfg", 4'd8);
      rd_chk("R1 load", 4'd9);
      rd_chk("R1 data3", 4'd3);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: config layout
      wr(4'd8, 16'hF0A5);
      out_chk("R2");
      rd_chk("R2 readback", 4'd8);
      // R3: immediate channel
      wr(4'd0, 16'hF123);
      out_chk("R3");
      // R4: deferred channel
      wr(4'd5, 16'h0ABC);
      out_chk("R4");
      chk("R4 latch5 unchanged", 96'(dac_code[60 +: 12]), 96'h0);
      // R10: readback zero-extended, unmapped address
      rd_chk("R10 data5", 4'd5);
      wr(4'd12, 16'hFFFF);
      rd_chk("R10 unmapped", 4'd12);
      out_chk("R10");
      // R6: near-miss keys
      wr(4'd9, 16'hBB01);
      idle();
      out_chk("R6 BB01");
      rd_chk("R6 held", 4'd9);
      wr(4'd9, 16'h3B00);
      idle();
      out_chk("R6 3B00");
      rd_chk("R6 held2", 4'd9);
      // R5, R7: key load
      wr(4'd9, KEY);
      rd_chk("R7 key visible", 4'd9);
      out_chk("R5 before strobe edge");
      idle();
      exp_ld = '0; m_load();
      out_chk("R5 after load");
      chk("R5 latch5", 96'(dac_code[60 +: 12]), 96'hABC);
      chk("R5 async ch0 untouched", 96'(dac_code[0 +: 12]), 96'h123);
      rd_chk("R7 cleared", 4'd9);
      // R9: write coinciding with strobe
      wr(4'd6, 16'h0111);
      wr(4'd9, KEY);
      exp_ld = '0; m_load();
      wr(4'd6, 16'h0222);
      out_chk("R9");
      chk("R9 latch6 old", 96'(dac_code[72 +: 12]), 96'h111);
      rd_chk("R9 data6 new", 4'd6);
      rd_chk("R7 cleared after R9", 4'd9);
      // R7: rewrite during strobe cycle wins over clear
      wr(4'd9, KEY);
      m_load();
      wr(4'd9, 16'h0042);
      rd_chk("R7 rewrite wins", 4'd9);
      idle();
      rd_chk("R7 rewrite held", 4'd9);
      // R8: external pin
      wr(4'd7, 16'h0777);
      ext_load = 1'b1;
      idle(); idle();
      out_chk("R8 not yet");
      idle();
      m_load();
      out_chk("R8 loaded");
      chk("R8 latch7", 96'(dac_code[84 +: 12]), 96'h777);
      wr(4'd7, 16'h0555);
      repeat (6) idle();
      out_chk("R8 level no reload");
      ext_load = 1'b0;
      repeat (4) idle();
      out_chk("R8 fall no load");

      // random mix
      for (int it = 0; it < 400; it++) begin
         logic [3:0] a;
         logic [15:0] d;
         a = 4'($urandom_range(0, 9));
         d = 16'($urandom);
         if (a == 9 && ($urandom_range(0, 1) == 0)) d = KEY;
         wr(a, d);
         if (a == 9 && d == KEY) begin
            idle();
            exp_ld = '0; m_load();
         end
         out_chk(a < 8 ? ((exp_cfg[8 + a]) ? "R4 rnd" : "R3 rnd") :
                 (a == 8 ? "R2 rnd" : "R5 rnd"));
         rd_chk("R10 rnd read", 4'($urandom_range(0, 15)));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule